// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

A bank of up to 32 general-purpose pins controlled over a simple register bus: a request strobe, a write flag, a word address and 32-bit write data, with read data returned one cycle after a read request. Each pin has an output value and an output-enable. Software changes these only through write-one-to-set and write-one-to-clear addresses. This lets one agent change a pin without a read-modify-write that could race with another agent. Software reads the output and direction state from their own addresses.

Incoming pin levels pass through a two-stage synchronizer. A pin's edge is found by comparing its synchronized level with the level from one cycle earlier. Rising and falling edges are gated by separate per-pin enable masks, and every enabled edge is latched into a sticky status word. The single interrupt line is high while any status bit is set, and software clears status bits by writing ones. Level triggering does not exist.

A second, independent pair of rising and falling masks selects the edges that raise a one-cycle wake pulse. A per-pin keep mask suppresses wake for pins that software wants left undisturbed during sleep.

Top module: `gpeb_top`

## Requirements
- R1: After reset every control register, the status word, pin_o, pin_oe_o, irq_o, wake_o and bus_rvalid_o are zero.
- R2: A write to address 2 sets the output bits where wdata has ones, and a write to address 3 clears them. Zero bits leave outputs unchanged. Address 1 reads the output register, and pin_o reflects it one cycle after the write.
- R3: A write to address 5 makes the pins at its one-bits outputs, and a write to address 6 makes them inputs. Address 4 reads the direction, 1 meaning output, and pin_oe_o follows it.
- R4: Address 0 reads the pin levels after the two-stage synchronizer. A change on pin_i is not visible to a read captured at the second clock edge after the change, and it is visible to later reads.
- R5: The rising-enable mask is read and written at address 7. A rising edge on an enabled pin sets that pin's status bit. A falling edge on a pin enabled only for rising edges does not set it, and neither does any edge on a pin with no enables.
- R6: The falling-enable mask is read and written at address 8. A falling edge on an enabled pin sets its status bit, and a pin with both masks set catches both edges.
- R7: A pin held at a steady level never sets its status bit, so only edges are detected.
- R8: Address 9 reads the status word. Writing to address 10 clears the status bits where wdata has ones, and other bits stay set.
- R9: irq_o is high exactly while at least one status bit is set, three clock edges after the triggering pin_i change.
- R10: If an enabled edge and a clear of the same status bit fall in the same cycle, the bit stays set.
- R11: The wake rising mask is at address 11 and the wake falling mask is at address 12. An edge selected by these masks raises wake_o for exactly one cycle, and this does not depend on the interrupt masks or the status word. The keep mask at address 13 blocks wake for the pins at its one-bits.
- R12: For pins at or above NUM_PINS, register bits read as zero and writes to them have no effect.
- R13: Reads of unmapped addresses 14 and 15 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| pin_i | input | NUM_PINS | Pin levels from the pads |
| pin_o | output | NUM_PINS | Output values |
| pin_oe_o | output | NUM_PINS | Output enables |
| irq_o | output | 1 | Combined interrupt |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
In one test an edge and a status clear land on the same clock edge. A design that lets the clear win drops an event and leaves the status bit at zero. Another test reads the level register one cycle too early after a pin change. A synchronizer with a missing stage shows the new level in that read, and edges caught on the wrong polarity set status bits that should stay clear. Other tests hold a pin at a steady level after its status is cleared, to catch level triggering, and count wake pulses, so that a stretched pulse, a wake gated by the interrupt masks or a keep bit that is ignored changes the count. The bench uses a pin count below the bus width and also writes to unmapped addresses, so that any bit outside the bank that can be written shows up in a readback.

// File: rtl/gpeb_pkg.sv
package gpeb_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_LEVEL      = 4'd0,
    A_OUT        = 4'd1,
    A_OUT_SET    = 4'd2,
    A_OUT_CLR    = 4'd3,
    A_DIR        = 4'd4,
    A_DIR_SET    = 4'd5,
    A_DIR_CLR    = 4'd6,
    A_RISE_EN    = 4'd7,
    A_FALL_EN    = 4'd8,
    A_STATUS     = 4'd9,
    A_STATUS_CLR = 4'd10,
    A_WAKE_RISE  = 4'd11,
    A_WAKE_FALL  = 4'd12,
    A_KEEP       = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/gpeb_sync.sv
module gpeb_sync #(
  parameter int NUM_PINS = 32,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  logic [NUM_PINS-1:0] stg_q [STAGES];
  logic [NUM_PINS-1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[g] <= '0;
      else if (g == 0) stg_q[g] <= pin_i;
      else             stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign level_o = stg_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_o;
  end

  assign rise_o = level_o & ~prev_q;
  assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/gpeb_regs.sv
module gpeb_regs
  import gpeb_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] out_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] rise_en_o,
  output logic [NUM_PINS-1:0] fall_en_o,
  output logic [NUM_PINS-1:0] wake_rise_o,
  output logic [NUM_PINS-1:0] wake_fall_o,
  output logic [NUM_PINS-1:0] keep_o,
  output logic                clr_valid_o,
  output logic [NUM_PINS-1:0] clr_mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o       <= '0;
      dir_o       <= '0;
      rise_en_o   <= '0;
      fall_en_o   <= '0;
      wake_rise_o <= '0;
      wake_fall_o <= '0;
      keep_o      <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_OUT_SET:   out_o       <= out_o | wdata_i;
        A_OUT_CLR:   out_o       <= out_o & ~wdata_i;
        A_DIR_SET:   dir_o       <= dir_o | wdata_i;
        A_DIR_CLR:   dir_o       <= dir_o & ~wdata_i;
        A_RISE_EN:   rise_en_o   <= wdata_i;
        A_FALL_EN:   fall_en_o   <= wdata_i;
        A_WAKE_RISE: wake_rise_o <= wdata_i;
        A_WAKE_FALL: wake_fall_o <= wdata_i;
        A_KEEP:      keep_o      <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_valid_o = wr_en_i && (addr_i == A_STATUS_CLR);
  assign clr_mask_o  = wdata_i;

  assert_out_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_OUT_SET) |=> ((out_o & $past(wdata_i)) == $past(wdata_i)));

  assert_dir_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DIR_CLR) |=> ((dir_o & $past(wdata_i)) == '0));
endmodule

// File: rtl/gpeb_events.sv
module gpeb_events #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] rise_i,
  input  logic [NUM_PINS-1:0] fall_i,
  input  logic [NUM_PINS-1:0] rise_en_i,
  input  logic [NUM_PINS-1:0] fall_en_i,
  input  logic [NUM_PINS-1:0] wake_rise_i,
  input  logic [NUM_PINS-1:0] wake_fall_i,
  input  logic [NUM_PINS-1:0] keep_i,
  input  logic                clr_valid_i,
  input  logic [NUM_PINS-1:0] clr_mask_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] ev_irq, ev_wake, clr_eff;

  assign ev_irq  = (rise_i & rise_en_i) | (fall_i & fall_en_i);
  assign ev_wake = ((rise_i & wake_rise_i) | (fall_i & wake_fall_i)) & ~keep_i;
  assign clr_eff = clr_valid_i ? clr_mask_i : '0;

  // new edge outranks a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      wake_o   <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_eff) | ev_irq;
      wake_o   <= |ev_wake;
    end
  end

  assign irq_o = |status_o;

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_valid_i |=> (($past(status_o) & ~status_o) == '0));

  assert_edge_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_valid_i && (ev_irq & clr_mask_i) != '0)
      |=> ((status_o & $past(ev_irq & clr_mask_i)) == $past(ev_irq & clr_mask_i)));

  assert_no_spurious_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(ev_irq)) == '0));
endmodule

// File: rtl/gpeb_top.sv
module gpeb_top
  import gpeb_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32,
  parameter int STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                bus_rvalid_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] level, rise, fall;
  logic [NUM_PINS-1:0] out_q, dir_q, rise_en, fall_en, wake_rise, wake_fall, keep;
  logic [NUM_PINS-1:0] status, clr_mask, rd_sel;
  logic                clr_valid, wr_en;
  logic [DATA_W-1:0]   rd_full;

  assign wr_en = bus_req_i & bus_we_i;

  gpeb_sync #(.NUM_PINS(NUM_PINS), .STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i,
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  gpeb_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i[NUM_PINS-1:0]),
    .out_o(out_q), .dir_o(dir_q), .rise_en_o(rise_en), .fall_en_o(fall_en),
    .wake_rise_o(wake_rise), .wake_fall_o(wake_fall), .keep_o(keep),
    .clr_valid_o(clr_valid), .clr_mask_o(clr_mask)
  );

  gpeb_events #(.NUM_PINS(NUM_PINS)) u_events (
    .clk_i, .rst_ni,
    .rise_i(rise), .fall_i(fall), .rise_en_i(rise_en), .fall_en_i(fall_en),
    .wake_rise_i(wake_rise), .wake_fall_i(wake_fall), .keep_i(keep),
    .clr_valid_i(clr_valid), .clr_mask_i(clr_mask),
    .status_o(status), .irq_o(irq_o), .wake_o(wake_o)
  );

  always_comb begin
    case (bus_addr_i)
      A_LEVEL:     rd_sel = level;
      A_OUT:       rd_sel = out_q;
      A_DIR:       rd_sel = dir_q;
      A_RISE_EN:   rd_sel = rise_en;
      A_FALL_EN:   rd_sel = fall_en;
      A_STATUS:    rd_sel = status;
      A_WAKE_RISE: rd_sel = wake_rise;
      A_WAKE_FALL: rd_sel = wake_fall;
      A_KEEP:      rd_sel = keep;
      default:     rd_sel = '0;
    endcase
    rd_full = '0;
    rd_full[NUM_PINS-1:0] = rd_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      bus_rvalid_o <= bus_req_i & ~bus_we_i;
      if (bus_req_i && !bus_we_i) bus_rdata_o <= rd_full;
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;

  assert_irq_tracks_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status != '0) |-> irq_o);
endmodule

// File: tb/sim_gpeb_top.sv
module sim_gpeb_top;
  localparam int N = 24;
  localparam logic [31:0] PM = 32'h00FF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [N-1:0] pin_in, pin_out, pin_oe, ext_drv = '0;
  logic irq, wake;

  int n_chk = 0, n_err = 0, wake_cnt = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_drv);

  gpeb_top #(.NUM_PINS(N), .DATA_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(bus_req), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R13 unexpected read response", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
    if (wake) wake_cnt++;
  end

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_o", 32'(pin_out), 0);
    check("R1 pin_oe_o", 32'(pin_oe), 0);
    check("R1 irq_o", 32'(irq), 0);
    check("R1 wake_o", 32'(wake), 0);
    bus_read(4'd1, 0, "R1 out reg");
    bus_read(4'd4, 0, "R1 dir reg");
    bus_read(4'd9, 0, "R1 status");
    bus_read(4'd7, 0, "R1 rise enable");

    // R2 atomic output set/clear
    bus_write(4'd2, 32'h0000_00F5);
    check("R2 pin_o after set", 32'(pin_out), 32'hF5);
    bus_read(4'd1, 32'hF5, "R2 out after set");
    bus_write(4'd3, 32'h0000_0005);
    bus_read(4'd1, 32'hF0, "R2 out after clear");
    bus_write(4'd2, 32'h0);
    bus_read(4'd1, 32'hF0, "R2 zero set no effect");

    // R3 direction
    bus_write(4'd5, 32'h0F);
    bus_read(4'd4, 32'h0F, "R3 dir after set");
    bus_write(4'd6, 32'h03);
    bus_read(4'd4, 32'h0C, "R3 dir after clear");
    check("R3 pin_oe_o", 32'(pin_oe), 32'h0C);

    // R4 level through synchronizer
    ext_drv = 24'h00A000;
    settle();
    bus_read(4'd0, 32'h0000_A000, "R4 level inputs");
    bus_write(4'd2, 32'h4);
    settle();
    bus_read(4'd0, 32'h0000_A004, "R4 level with driven pin");
    @(negedge clk);
    ext_drv[16] = 1'b1;
    bus_read(4'd0, 32'h0000_A004, "R4 not visible before two stages");
    bus_read(4'd0, 32'h0001_A004, "R4 visible after two stages");
    bus_write(4'd6, 32'hFFFF_FFFF);
    bus_write(4'd3, 32'hFFFF_FFFF);
    ext_drv = '0;
    settle();
    bus_read(4'd9, 0, "R5 no enables no status");
    check("R9 irq low without status", 32'(irq), 0);

    // R5/R6 edge masks
    bus_write(4'd7, 32'h1);
    bus_write(4'd8, 32'h2);
    bus_read(4'd7, 32'h1, "R5 rise enable readback");
    bus_read(4'd8, 32'h2, "R6 fall enable readback");
    @(negedge clk); ext_drv[0] = 1'b1; settle();
    bus_read(4'd9, 32'h1, "R5 rise sets status");
    check("R9 irq high", 32'(irq), 1);
    @(negedge clk); ext_drv[1] = 1'b1; settle();
    @(negedge clk); ext_drv[0] = 1'b0; settle();
    bus_read(4'd9, 32'h1, "R5 wrong-polarity edges ignored");
    @(negedge clk); ext_drv[1] = 1'b0; settle();
    bus_read(4'd9, 32'h3, "R6 fall sets status");

    // R8 clear
    bus_write(4'd10, 32'h1);
    bus_read(4'd9, 32'h2, "R8 partial clear");
    check("R9 irq still high", 32'(irq), 1);
    bus_write(4'd10, 32'h2);
    bus_read(4'd9, 32'h0, "R8 full clear");
    check("R9 irq low after clear", 32'(irq), 0);

    // R7 no level triggering
    bus_write(4'd7, 32'h11);
    @(negedge clk); ext_drv[4] = 1'b1; settle();
    bus_read(4'd9, 32'h10, "R7 rise on pin4");
    bus_write(4'd10, 32'h10);
    repeat (10) @(negedge clk);
    bus_read(4'd9, 32'h0, "R7 steady high no retrigger");
    check("R7 irq stays low", 32'(irq), 0);

    // R6 both edges, R10 edge beats clear
    bus_write(4'd8, 32'h12);
    @(negedge clk); ext_drv[4] = 1'b0; settle();
    bus_read(4'd9, 32'h10, "R6 both-edge pin falls");
    @(negedge clk); ext_drv[4] = 1'b1;
    @(negedge clk);
    bus_write(4'd10, 32'h10);
    settle();
    bus_read(4'd9, 32'h10, "R10 coincident edge keeps bit");
    bus_write(4'd10, 32'h10);
    bus_read(4'd9, 32'h0, "R10 later clear works");

    // R11 wake
    bus_write(4'd11, 32'h100);
    w0 = wake_cnt;
    @(negedge clk); ext_drv[8] = 1'b1; settle();
    check("R11 one wake pulse on rise", 32'(wake_cnt - w0), 1);
    bus_read(4'd9, 32'h0, "R11 wake independent of status");
    w0 = wake_cnt;
    @(negedge clk); ext_drv[8] = 1'b0; settle();
    check("R11 no wake on unmasked fall", 32'(wake_cnt - w0), 0);
    bus_write(4'd13, 32'h100);
    bus_read(4'd13, 32'h100, "R11 keep readback");
    w0 = wake_cnt;
    @(negedge clk); ext_drv[8] = 1'b1; settle();
    check("R11 keep blocks wake", 32'(wake_cnt - w0), 0);
    bus_write(4'd13, 32'h0);
    bus_write(4'd12, 32'h100);
    w0 = wake_cnt;
    @(negedge clk); ext_drv[8] = 1'b0; settle();
    check("R11 wake on masked fall", 32'(wake_cnt - w0), 1);

    // R12 bits beyond pin count
    bus_write(4'd2, 32'hFF00_0000);
    bus_read(4'd1, 32'h0, "R12 high out bits absent");
    bus_write(4'd7, 32'hFFFF_FFFF);
    bus_read(4'd7, PM, "R12 enable masked to pin count");
    bus_write(4'd7, 32'h0);

    // R13 unmapped addresses
    bus_read(4'd14, 32'h0, "R13 unmapped read");
    bus_write(4'd15, 32'hFFFF_FFFF);
    bus_read(4'd1, 32'h0, "R13 unmapped write out");
    bus_read(4'd4, 32'h0, "R13 unmapped write dir");
    bus_read(4'd15, 32'h0, "R13 unmapped read 15");

    repeat (3) @(negedge clk);
    check("R13 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule